// File: doc/BRIEF.md
# I2C Single-Word Transaction Sequencer

This block carries out one whole I2C master transaction from a single 64-bit command word, so software needs no handshake per byte. Software loads a 40-bit extension register if it needs one, then writes the command word with its valid bit set. The sequencer then drives a byte-level bus engine through START, address, optional internal-address bytes, data, repeated START and STOP requests. When the transfer ends, the hardware clears the valid bit and raises a one-cycle completion interrupt.

Two kinds of transfer are supported. A plain transfer reads or writes 1 to 8 bytes. A combined transfer first writes a 1- or 2-byte internal address and then writes or reads the data. Data bytes sit in eight byte lanes in reversed order: lanes 0 to 3 are command bits 31:0 and lanes 4 to 7 are extension bits 31:0. Byte k of an n-byte message uses lane n-1-k. Read data is returned in the same lanes. When a transfer fails, the read bit is cleared and a status code replaces the low byte.

Top module: `i2c_cmd_engine`

## Requirements
- R1: The command word layout is: bit 63 valid, bit 62 read, bits 61:58 opcode (0 plain, 1 combined), bit 57 two-byte internal address, bits 54:52 byte count minus one, bits 46:40 target address, bits 39:32 low internal-address byte, bits 31:0 lanes 0 to 3. After reset both registers and all outputs are zero. A command write with bit 63 set while the block is idle starts a transfer whose first bus request is START. A command write with bit 63 clear only stores the word.
- R2: The valid bit drops in the same cycle that `irq` is high for exactly one cycle. This happens at the clock edge that accepts the bus engine's completion of the final STOP. For an unsupported opcode it happens one cycle after acceptance.
- R3: Write data is sent first byte first, taken from lanes n-1 down to 0. Lanes 4 to 7 come from extension bits 31:0.
- R4: A read requests one receive (`be_op`=3) per byte. `be_ack`=1 on every byte except the last, where `be_ack`=0. The k-th received byte is stored into lane n-1-k. On success the read bit stays 1.
- R5: Bus request codes are 0 START, 1 STOP, 2 send byte, 3 receive byte. A plain transfer issues START, then the address byte {address, read bit}, then the data bytes, then STOP. Each request is a one-cycle `be_req` pulse, followed by a wait for `be_done`.
- R6: A combined write issues START and {address,0}. If bit 57 is set it then sends extension bits 39:32, and after that it sends command bits 39:32. The data bytes and STOP follow.
- R7: A combined read sends the internal-address phase as in R6. It then issues a second START, {address,1}, the received bytes and STOP.
- R8: If the peer NAKs (`be_nak` with `be_done`) a sent byte, the next request is STOP. The read bit is then cleared and bits 7:0 take a status: 0x20 for the write-address byte, 0x48 for the read-address byte, and 0x30 for an internal-address or data byte.
- R9: An opcode other than 0 or 1 issues no bus request. It completes with the read bit cleared and status 0xF8.
- R10: While bit 63 is set, writes to the command or extension register are ignored. This includes the cycle in which the transfer completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_wdata | input | 64 | Command word to write |
| ext_wr | input | 1 | Extension register write strobe |
| ext_wdata | input | 40 | Extension value to write |
| cmd_q | output | 64 | Command register contents |
| ext_q | output | 40 | Extension register contents |
| irq | output | 1 | One-cycle completion pulse |
| be_req | output | 1 | Bus engine request pulse |
| be_op | output | 2 | Requested bus operation |
| be_txbyte | output | 8 | Byte to send |
| be_ack | output | 1 | ACK (1) or NAK (0) for a received byte |
| be_done | input | 1 | Bus engine finished the request |
| be_nak | input | 1 | Peer did not acknowledge the sent byte |
| be_rxbyte | input | 8 | Received byte, valid with be_done |

## Verification
A register write from software and the hardware completion can land in the same clock cycle. The valid bit is cleared at the same edge that accepts the final STOP completion. A command or extension write arriving at that edge must still be treated as a write during a busy transfer. The bench provokes this by timing a command write, with the valid bit and a bad opcode set, together with a conflicting extension write, so that both arrive in the exact cycle the bus model raises `be_done` for STOP. The bench judges the outcome three ways: the returned command and extension values must equal the completed transfer's result, no second transfer may start, and the cycle-level model must see valid fall and `irq` pulse once.

// File: rtl/i2c_cmd_pkg.sv
// Shared constants and types for the single-word I2C transaction sequencer.
// Assumes a 64-bit command word and a 40-bit extension register.
package i2c_cmd_pkg;
    localparam int CMD_W   = 64;
    localparam int EXT_W   = 40;
    localparam int LANES   = 8;
    localparam int LANE_W  = $clog2(LANES);
    localparam int HALF    = LANES / 2;

    localparam int F_VALID = 63;
    localparam int F_READ  = 62;
    localparam int F_OP_HI = 61;
    localparam int F_OP_LO = 58;
    localparam int F_EIA   = 57;
    localparam int F_SZ_HI = 54;
    localparam int F_SZ_LO = 52;
    localparam int F_AD_HI = 46;
    localparam int F_AD_LO = 40;
    localparam int F_IA_HI = 39;
    localparam int F_IA_LO = 32;

    localparam logic [3:0] OPC_PLAIN = 4'h0;
    localparam logic [3:0] OPC_IADDR = 4'h1;

    localparam logic [7:0] ST_AW_NAK = 8'h20;
    localparam logic [7:0] ST_TD_NAK = 8'h30;
    localparam logic [7:0] ST_AR_NAK = 8'h48;
    localparam logic [7:0] ST_BAD_OP = 8'hF8;

    typedef enum logic [1:0] {
        BE_START = 2'd0,
        BE_STOP  = 2'd1,
        BE_TX    = 2'd2,
        BE_RX    = 2'd3
    } be_op_e;

    typedef enum logic [2:0] {
        PH_START, PH_ADDR_W, PH_IA_HI, PH_IA_LO,
        PH_RSTART, PH_ADDR_R, PH_DATA, PH_STOP
    } phase_e;

    typedef enum logic [1:0] {
        S_IDLE, S_ISSUE, S_WAIT
    } seq_state_e;
endpackage

// File: rtl/i2c_cmd_regs.sv
// Command and extension registers with byte-lane access.
// Accepts software writes only while no transfer is pending, stores received
// bytes into their lanes and applies the completion/failure update.
// Assumes fin and rx_we never occur in the same cycle.
module i2c_cmd_regs
    import i2c_cmd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_wr,
    input  logic [CMD_W-1:0]     cmd_wdata,
    input  logic                 ext_wr,
    input  logic [EXT_W-1:0]     ext_wdata,
    input  logic                 fin,
    input  logic                 fin_fail,
    input  logic [7:0]           fin_status,
    input  logic                 rx_we,
    input  logic [LANE_W-1:0]    lane,
    input  logic [7:0]           rx_byte,
    output logic [CMD_W-1:0]     cmd_q,
    output logic [EXT_W-1:0]     ext_q,
    output logic [7:0]           lane_byte,
    output logic                 irq
);
    logic       busy;
    logic [7:0] lanes [LANES];

    assign busy = cmd_q[F_VALID];

    // Map the eight byte lanes onto the two registers.
    for (genvar g = 0; g < HALF; g++) begin : g_lane
        assign lanes[g]        = cmd_q[8*g +: 8];
        assign lanes[g + HALF] = ext_q[8*g +: 8];
    end

    // Byte presented for sending in the current data phase.
    assign lane_byte = lanes[lane];

    // Command register: software load, read-data store, completion update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (!busy) begin
            if (cmd_wr) cmd_q <= cmd_wdata;
        end else begin
            if (rx_we && !lane[LANE_W-1])
                cmd_q[{lane[LANE_W-2:0], 3'b000} +: 8] <= rx_byte;
            if (fin) begin
                cmd_q[F_VALID] <= 1'b0;
                if (fin_fail) begin
                    cmd_q[F_READ] <= 1'b0;
                    cmd_q[7:0]    <= fin_status;
                end
            end
        end
    end

    // Extension register: software load or upper-lane read-data store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_q <= '0;
        end else if (!busy) begin
            if (ext_wr) ext_q <= ext_wdata;
        end else if (rx_we && lane[LANE_W-1]) begin
            ext_q[{lane[LANE_W-2:0], 3'b000} +: 8] <= rx_byte;
        end
    end

    // Completion pulse, aligned with the clearing of the valid bit.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= fin && busy;
    end
endmodule

// File: rtl/i2c_cmd_seq.sv
// Transaction sequencer: walks the bus phases of one command word.
// Issues one bus request per phase as a one-cycle pulse, then waits for
// be_done. Assumes the command fields stay constant while valid is set.
module i2c_cmd_seq
    import i2c_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic              rd,
    input  logic              eia,
    input  logic [3:0]        opc,
    input  logic [LANE_W-1:0] size,
    input  logic [6:0]        taddr,
    input  logic [7:0]        ia_lo,
    input  logic [7:0]        ia_hi,
    input  logic [7:0]        lane_byte,
    input  logic              be_done,
    input  logic              be_nak,
    output logic              be_req,
    output logic [1:0]        be_op,
    output logic [7:0]        be_txbyte,
    output logic              be_ack,
    output logic              rx_we,
    output logic [LANE_W-1:0] lane,
    output logic              fin,
    output logic              fin_fail,
    output logic [7:0]        fin_status
);
    seq_state_e        state;
    phase_e            phase, nxt_phase;
    logic [LANE_W-1:0] cnt, nxt_cnt;
    logic              fail_r, nxt_fail;
    logic [7:0]        stat_r, nxt_stat;
    logic              combined, bad_op, done_now;

    assign combined = (opc == OPC_IADDR);
    assign bad_op   = (opc != OPC_PLAIN) && (opc != OPC_IADDR);
    assign done_now = (state == S_WAIT) && be_done;

    // Completion: bad opcode at idle, or the final STOP acknowledged.
    assign fin        = ((state == S_IDLE) && valid && bad_op) ||
                        (done_now && (phase == PH_STOP));
    assign fin_fail   = (state == S_IDLE) ? 1'b1 : fail_r;
    assign fin_status = (state == S_IDLE) ? ST_BAD_OP : stat_r;

    // Read-data store strobe and lane of the current data byte.
    assign rx_we  = done_now && (phase == PH_DATA) && rd;
    assign lane   = size - cnt;
    assign be_req = (state == S_ISSUE);
    assign be_ack = (cnt != size);

    // Bus operation code for the current phase.
    always_comb begin
        case (phase)
            PH_START, PH_RSTART: be_op = BE_START;
            PH_STOP:             be_op = BE_STOP;
            PH_DATA:             be_op = rd ? BE_RX : BE_TX;
            default:             be_op = BE_TX;
        endcase
    end

    // Byte to send for the current phase.
    always_comb begin
        case (phase)
            PH_ADDR_W: be_txbyte = {taddr, 1'b0};
            PH_ADDR_R: be_txbyte = {taddr, 1'b1};
            PH_IA_HI:  be_txbyte = ia_hi;
            PH_IA_LO:  be_txbyte = ia_lo;
            default:   be_txbyte = lane_byte;
        endcase
    end

    // Next phase, counter and failure status once a request completes.
    always_comb begin
        nxt_phase = phase;
        nxt_cnt   = cnt;
        nxt_fail  = fail_r;
        nxt_stat  = stat_r;
        case (phase)
            PH_START:  nxt_phase = (rd && !combined) ? PH_ADDR_R : PH_ADDR_W;
            PH_ADDR_W: begin
                if (be_nak) begin
                    nxt_fail = 1'b1; nxt_stat = ST_AW_NAK; nxt_phase = PH_STOP;
                end else if (combined) begin
                    nxt_phase = eia ? PH_IA_HI : PH_IA_LO;
                end else begin
                    nxt_phase = PH_DATA;
                end
            end
            PH_IA_HI: begin
                if (be_nak) begin
                    nxt_fail = 1'b1; nxt_stat = ST_TD_NAK; nxt_phase = PH_STOP;
                end else begin
                    nxt_phase = PH_IA_LO;
                end
            end
            PH_IA_LO: begin
                if (be_nak) begin
                    nxt_fail = 1'b1; nxt_stat = ST_TD_NAK; nxt_phase = PH_STOP;
                end else begin
                    nxt_phase = rd ? PH_RSTART : PH_DATA;
                end
            end
            PH_RSTART: nxt_phase = PH_ADDR_R;
            PH_ADDR_R: begin
                if (be_nak) begin
                    nxt_fail = 1'b1; nxt_stat = ST_AR_NAK; nxt_phase = PH_STOP;
                end else begin
                    nxt_phase = PH_DATA;
                end
            end
            PH_DATA: begin
                if (!rd && be_nak) begin
                    nxt_fail = 1'b1; nxt_stat = ST_TD_NAK; nxt_phase = PH_STOP;
                end else if (cnt == size) begin
                    nxt_phase = PH_STOP;
                end else begin
                    nxt_cnt = cnt + 1'b1;
                end
            end
            default: nxt_phase = phase;
        endcase
    end

    // Sequencer state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            phase  <= PH_START;
            cnt    <= '0;
            fail_r <= 1'b0;
            stat_r <= 8'h00;
        end else begin
            case (state)
                S_IDLE: begin
                    if (valid && !bad_op) begin
                        state  <= S_ISSUE;
                        phase  <= PH_START;
                        cnt    <= '0;
                        fail_r <= 1'b0;
                        stat_r <= 8'h00;
                    end
                end
                S_ISSUE: state <= S_WAIT;
                S_WAIT: begin
                    if (be_done) begin
                        phase  <= nxt_phase;
                        cnt    <= nxt_cnt;
                        fail_r <= nxt_fail;
                        stat_r <= nxt_stat;
                        state  <= (phase == PH_STOP) ? S_IDLE : S_ISSUE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/i2c_cmd_engine.sv
// Top of the single-word I2C transaction sequencer: register file plus
// phase sequencer. Assumes a byte-level bus engine that answers each
// request pulse with a one-cycle be_done.
module i2c_cmd_engine
    import i2c_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [CMD_W-1:0]  cmd_wdata,
    input  logic              ext_wr,
    input  logic [EXT_W-1:0]  ext_wdata,
    output logic [CMD_W-1:0]  cmd_q,
    output logic [EXT_W-1:0]  ext_q,
    output logic              irq,
    output logic              be_req,
    output logic [1:0]        be_op,
    output logic [7:0]        be_txbyte,
    output logic              be_ack,
    input  logic              be_done,
    input  logic              be_nak,
    input  logic [7:0]        be_rxbyte
);
    logic              fin, fin_fail, rx_we;
    logic [7:0]        fin_status, lane_byte;
    logic [LANE_W-1:0] lane;

    i2c_cmd_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_wr     (cmd_wr),
        .cmd_wdata  (cmd_wdata),
        .ext_wr     (ext_wr),
        .ext_wdata  (ext_wdata),
        .fin        (fin),
        .fin_fail   (fin_fail),
        .fin_status (fin_status),
        .rx_we      (rx_we),
        .lane       (lane),
        .rx_byte    (be_rxbyte),
        .cmd_q      (cmd_q),
        .ext_q      (ext_q),
        .lane_byte  (lane_byte),
        .irq        (irq)
    );

    i2c_cmd_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid      (cmd_q[F_VALID]),
        .rd         (cmd_q[F_READ]),
        .eia        (cmd_q[F_EIA]),
        .opc        (cmd_q[F_OP_HI:F_OP_LO]),
        .size       (cmd_q[F_SZ_HI:F_SZ_LO]),
        .taddr      (cmd_q[F_AD_HI:F_AD_LO]),
        .ia_lo      (cmd_q[F_IA_HI:F_IA_LO]),
        .ia_hi      (ext_q[EXT_W-1:EXT_W-8]),
        .lane_byte  (lane_byte),
        .be_done    (be_done),
        .be_nak     (be_nak),
        .be_req     (be_req),
        .be_op      (be_op),
        .be_txbyte  (be_txbyte),
        .be_ack     (be_ack),
        .rx_we      (rx_we),
        .lane       (lane),
        .fin        (fin),
        .fin_fail   (fin_fail),
        .fin_status (fin_status)
    );
endmodule

// File: rtl/i2c_cmd_engine_chk.sv
// Property checker for the transaction sequencer, bound to the top module.
// Assumes synchronous active-low reset.
module i2c_cmd_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        valid,
    input logic [29:0] hold_fields,
    input logic [7:0]  ext_ia,
    input logic        irq,
    input logic        be_req
);
    // R1: bus requests only while a transfer is pending.
    p_req_needs_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        be_req |-> valid);

    // R2: the interrupt marks the cycle valid has just dropped.
    p_irq_on_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (!valid && $past(valid)));

    // R2: the interrupt lasts one cycle.
    p_irq_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R5: each request is a single-cycle pulse.
    p_req_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        be_req |=> !be_req);

    // R10: control fields and high internal address hold while busy.
    p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && $past(valid)) |-> ($stable(hold_fields) && $stable(ext_ia)));
endmodule

bind i2c_cmd_engine i2c_cmd_engine_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid       (cmd_q[63]),
    .hold_fields (cmd_q[61:32]),
    .ext_ia      (ext_q[39:32]),
    .irq         (irq),
    .be_req      (be_req)
);

// File: tb/test_i2c_cmd_engine.sv
module test_i2c_cmd_engine;
    import i2c_cmd_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [63:0] cmd_wdata = '0;
    logic        ext_wr = 1'b0;
    logic [39:0] ext_wdata = '0;
    logic [63:0] cmd_q;
    logic [39:0] ext_q;
    logic        irq, be_req, be_ack;
    logic [1:0]  be_op;
    logic [7:0]  be_txbyte;
    logic        be_done = 1'b0;
    logic        be_nak = 1'b0;
    logic [7:0]  be_rxbyte = '0;

    always #5 clk = ~clk;

    i2c_cmd_engine i_i2c_cmd_engine (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .ext_wr(ext_wr), .ext_wdata(ext_wdata), .cmd_q(cmd_q), .ext_q(ext_q),
        .irq(irq), .be_req(be_req), .be_op(be_op), .be_txbyte(be_txbyte),
        .be_ack(be_ack), .be_done(be_done), .be_nak(be_nak), .be_rxbyte(be_rxbyte)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
        end
    endtask

    // Expected bus request list and final register values.
    int          e_op[$];
    logic [7:0]  e_byte[$];
    bit          e_ack[$];
    int          e_kind[$];
    logic [63:0] exp_cmd;
    logic [39:0] exp_ext;
    logic [7:0]  rx_data [8];
    int          op_seen = 0;
    int          rx_k = 0;
    int          nak_at = -1;
    string       cur_tag = "R5";

    function automatic void push(input int op, input logic [7:0] b, input bit a, input int k);
        e_op.push_back(op); e_byte.push_back(b); e_ack.push_back(a); e_kind.push_back(k);
    endfunction

    function automatic logic [7:0] lane_of(input logic [63:0] c, input logic [39:0] e, input int l);
        return (l < 4) ? c[8*l +: 8] : e[8*(l-4) +: 8];
    endfunction

    function automatic void plan(input logic [63:0] c, input logic [39:0] e, input int nk);
        int n = int'(c[54:52]) + 1;
        logic [6:0] a = c[46:40];
        bit rd = c[62];
        int oc = int'(c[61:58]);
        bit fail = 0;
        logic [7:0] st = 8'h00;
        int k = 0;
        e_op.delete(); e_byte.delete(); e_ack.delete(); e_kind.delete();
        exp_cmd = c; exp_ext = e; exp_cmd[63] = 1'b0;
        if (oc > 1) begin
            exp_cmd[62] = 1'b0; exp_cmd[7:0] = 8'hF8;
            return;
        end
        push(0, 8'h00, 0, 0);
        if (oc == 1 || !rd) push(2, {a, 1'b0}, 0, 1);
        if (oc == 1) begin
            if (c[57]) push(2, e[39:32], 0, 0);
            push(2, c[39:32], 0, 0);
        end
        if (rd) begin
            if (oc == 1) push(0, 8'h00, 0, 0);
            push(2, {a, 1'b1}, 0, 2);
            for (int i = 0; i < n; i++) push(3, 8'h00, i != n - 1, 3);
        end else begin
            for (int i = 0; i < n; i++) push(2, lane_of(c, e, n - 1 - i), 0, 0);
        end
        push(1, 8'h00, 0, 0);
        if (nk >= 0 && nk < e_op.size() && e_op[nk] == 2) begin
            fail = 1;
            st = (e_kind[nk] == 1) ? 8'h20 : (e_kind[nk] == 2) ? 8'h48 : 8'h30;
            while (e_op.size() > nk + 1) begin
                void'(e_op.pop_back()); void'(e_byte.pop_back());
                void'(e_ack.pop_back()); void'(e_kind.pop_back());
            end
            push(1, 8'h00, 0, 0);
        end
        for (int i = 0; i < e_op.size(); i++) begin
            if (e_op[i] == 3) begin
                int l = n - 1 - k;
                if (l < 4) exp_cmd[8*l +: 8] = rx_data[k];
                else       exp_ext[8*(l-4) +: 8] = rx_data[k];
                k++;
            end
        end
        if (fail) begin
            exp_cmd[62] = 1'b0; exp_cmd[7:0] = st;
        end
    endfunction

    // Bus engine responder: answers each request two cycles later.
    int cur_op_done = 0;
    initial begin
        int cnt = 0;
        int pend_idx = 0;
        int pend_op = 0;
        forever begin
            @(negedge clk);
            be_done = 1'b0;
            be_nak = 1'b0;
            if (cnt > 0) begin
                cnt--;
                if (cnt == 0) begin
                    be_done = 1'b1;
                    be_nak = (pend_idx == nak_at) && (pend_op == 2);
                    if (pend_op == 3) begin
                        be_rxbyte = rx_data[rx_k];
                        rx_k++;
                    end
                    cur_op_done = pend_op;
                end
            end else if (be_req) begin
                if (op_seen >= e_op.size()) begin
                    chk(0, "R5", "unexpected request", 64'(be_op), 64'hFF);
                end else begin
                    chk(int'(be_op) == e_op[op_seen], cur_tag, "request op", 64'(be_op), 64'(e_op[op_seen]));
                    if (e_op[op_seen] == 2)
                        chk(be_txbyte == e_byte[op_seen], cur_tag, "sent byte", 64'(be_txbyte), 64'(e_byte[op_seen]));
                    if (e_op[op_seen] == 3)
                        chk(be_ack == e_ack[op_seen], "R4", "ack flag", 64'(be_ack), 64'(e_ack[op_seen]));
                end
                pend_idx = op_seen;
                pend_op = int'(be_op);
                op_seen++;
                cnt = 2;
            end
        end
    end

    // Cycle-level reference model of the valid bit and the interrupt.
    bit busy_m = 0;
    bit irq_m = 0;
    bit bad_m = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            busy_m <= 0; irq_m <= 0; bad_m <= 0;
        end else begin
            irq_m <= 0;
            if (!busy_m) begin
                if (cmd_wr && cmd_wdata[63]) begin
                    busy_m <= 1;
                    bad_m <= (cmd_wdata[61:58] > 4'd1);
                end
            end else if (bad_m || (be_done && cur_op_done == 1)) begin
                busy_m <= 0; irq_m <= 1; bad_m <= 0;
            end
        end
    end

    bit mon_en = 0;
    initial begin
        forever begin
            @(negedge clk);
            if (mon_en) begin
                chk(cmd_q[63] == busy_m, "R2", "valid vs model", 64'(cmd_q[63]), 64'(busy_m));
                chk(irq == irq_m, "R2", "irq vs model", 64'(irq), 64'(irq_m));
            end
        end
    end

    function automatic logic [63:0] mk(input bit rd, input logic [3:0] oc, input bit eia,
                                       input int n, input logic [6:0] a, input logic [7:0] ia,
                                       input logic [31:0] lo);
        logic [63:0] c = '0;
        c[63] = 1'b1; c[62] = rd; c[61:58] = oc; c[57] = eia;
        c[54:52] = 3'(n - 1); c[46:40] = a; c[39:32] = ia; c[31:0] = lo;
        return c;
    endfunction

    task automatic run_txn(input logic [63:0] c, input logic [39:0] e, input int nk,
                           input bit collide, input string tag);
        int w = 0;
        plan(c, e, nk);
        op_seen = 0; rx_k = 0; nak_at = nk; cur_tag = tag;
        @(negedge clk); ext_wr = 1'b1; ext_wdata = e;
        @(negedge clk); ext_wr = 1'b0; cmd_wr = 1'b1; cmd_wdata = c;
        @(negedge clk); cmd_wr = 1'b0;
        do begin
            @(negedge clk);
            w++;
            cmd_wr = 1'b0; ext_wr = 1'b0;
            if (collide && w == 4) begin
                cmd_wr = 1'b1; cmd_wdata = 64'h0123_4567_89AB_CDEF; ext_wr = 1'b1; ext_wdata = 40'h55_5555_5555;
            end
            if (collide && be_req && be_op == 2'd1) begin
                @(negedge clk);
                @(negedge clk);
                cmd_wr = 1'b1; cmd_wdata = '1; ext_wr = 1'b1; ext_wdata = 40'hAA_AAAA_AAAA;
                @(negedge clk);
                cmd_wr = 1'b0; ext_wr = 1'b0;
            end
        end while (!irq && w < 3000);
        chk(w < 3000, tag, "completion seen", 64'(w), 64'd3000);
        chk(cmd_q == exp_cmd, tag, "command result", cmd_q, exp_cmd);
        chk(ext_q == exp_ext, tag, "extension result", 64'(ext_q), 64'(exp_ext));
        chk(op_seen == e_op.size(), tag, "request count", 64'(op_seen), 64'(e_op.size()));
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_up;
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(cmd_q == 64'h0 && ext_q == 40'h0, "R1", "reset registers", cmd_q, 64'h0);
        chk(irq == 1'b0 && be_req == 1'b0, "R1", "reset outputs", {irq, be_req}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        mon_en = 1;

        // R1: a write with the valid bit clear only stores the word
        e_op.delete(); op_seen = 0; cur_tag = "R1";
        cmd_wr = 1'b1; cmd_wdata = 64'h0000_0000_1234_5678;
        @(negedge clk); cmd_wr = 1'b0;
        repeat (6) @(negedge clk);
        chk(cmd_q == 64'h0000_0000_1234_5678, "R1", "stored without start", cmd_q, 64'h0000_0000_1234_5678);
        chk(op_seen == 0, "R1", "no request", 64'(op_seen), 64'h0);

        // R3, R5: plain writes, short and full eight bytes
        run_txn(mk(0, 4'h0, 0, 3, 7'h50, 8'h00, 32'h00AA_BBCC), 40'h0, -1, 0, "R3");
        run_txn(mk(0, 4'h0, 0, 8, 7'h2B, 8'h00, 32'h1122_3344), 40'h00_5566_7788, -1, 0, "R3");

        // R4: plain reads of one and eight bytes
        rx_data = '{8'hC1, 8'hC2, 8'hC3, 8'hC4, 8'hC5, 8'hC6, 8'hC7, 8'hC8};
        run_txn(mk(1, 4'h0, 0, 1, 7'h11, 8'h00, 32'hFFFF_FFFF), 40'hFF_FFFF_FFFF, -1, 0, "R4");
        run_txn(mk(1, 4'h0, 0, 8, 7'h12, 8'h00, 32'h0), 40'h0, -1, 0, "R4");

        // R6: combined writes with one- and two-byte internal address
        run_txn(mk(0, 4'h1, 0, 2, 7'h3C, 8'h9A, 32'h0000_D00D), 40'h0, -1, 0, "R6");
        run_txn(mk(0, 4'h1, 1, 6, 7'h3D, 8'h34, 32'hA1A2_A3A4), 40'h12_0000_B5B6, -1, 0, "R6");

        // R7: combined read with a two-byte internal address
        rx_data = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08};
        run_txn(mk(1, 4'h1, 1, 5, 7'h44, 8'h78, 32'h0), 40'h56_0000_0000, -1, 0, "R7");

        // R8: NAK on write address, data byte, read address (plain and combined)
        run_txn(mk(0, 4'h0, 0, 2, 7'h60, 8'h00, 32'h0000_1234), 40'h0, 1, 0, "R8");
        run_txn(mk(0, 4'h0, 0, 4, 7'h61, 8'h00, 32'h5566_7788), 40'h0, 3, 0, "R8");
        run_txn(mk(1, 4'h0, 0, 2, 7'h62, 8'h00, 32'h0), 40'h0, 1, 0, "R8");
        run_txn(mk(1, 4'h1, 0, 3, 7'h63, 8'h10, 32'h0), 40'h0, 4, 0, "R8");

        // R9: unsupported opcode
        run_txn(mk(1, 4'h5, 0, 2, 7'h70, 8'h00, 32'hCAFE_0000), 40'h0, -1, 0, "R9");

        // R10: writes while busy, including the completion cycle
        run_txn(mk(0, 4'h1, 1, 3, 7'h1F, 8'hEE, 32'h00BE_EF42), 40'hDD_0000_0000, -1, 1, "R10");
        chk(cmd_q[63] == 1'b0, "R10", "no start after collision", 64'(cmd_q[63]), 64'h0);

        finish_up();
    end
endmodule